// File: doc/BRIEF.md
# Backup Cell Isolation Detector

This block decides whether the backup cells feed the memory supply rail and the conditioned chip-enable outputs, or stay cut off from them so that a board holding no useful data does not drain its battery. All inputs are already digitised. Single-cycle events mark the supply falling through the failure threshold, the supply falling through the switch-over voltage, the supply becoming valid again, and the attachment of a fresh cell. Level flags come from a window comparator that watches the chip-enable pin, plus a flag that says the rechargeable cell has sagged below its usable level.

Firmware asks for isolation during a power-down. It parks chip enable in the mid-supply band after the failure crossing and before the switch-over crossing. The band must be held without a break for a parameterised number of clock cycles (70 cycles, 700 ns at 100 MHz), and chip enable must never go above the upper limit in that interval. The request takes effect when the switch-over crossing arrives. The isolation lasts until the supply has been applied once more and then removed. A second output picks the cell that carries the load during backup. It moves to the primary cell when the rechargeable cell runs low, and it stays there until the supply returns.

Top module: `batt_iso_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `batt_isolated_o` is 1 (isolated) and `prim_sel_o` is 0 (rechargeable cell selected).
- R2: A `cell_attach_i` pulse sets `batt_isolated_o` to 1 from the next cycle, whatever the current phase. After an attach, a supply removal does not reconnect the cell until a `supply_up_i` has been seen.
- R3: The window opens on the clock edge after a `fail_cross_i` pulse that is taken while the supply is valid. If `ce_midband_i` is then high on at least HOLD_CYCLES consecutive edges, all of them before the edge that samples `swo_cross_i`, then `batt_isolated_o` is 1 on the cycle after that edge.
- R4: A mid-band run one edge shorter than HOLD_CYCLES does not isolate. Neither do two shorter runs that together exceed HOLD_CYCLES, because any edge with `ce_midband_i` low restarts the count.
- R5: If `ce_over_i` is high on any edge inside the window, the request is void. This includes the edge that samples `swo_cross_i`.
- R6: `ce_midband_i` and `ce_over_i` have no effect while the supply is valid or while on backup.
- R7: A `supply_up_i` inside the window abandons it. A later `swo_cross_i` that arrives without a new `fail_cross_i` does not isolate.
- R8: When the cell is isolated and a `supply_up_i` has been seen since the isolation, the next removal (`fail_cross_i` or `swo_cross_i` while the supply is valid) clears `batt_isolated_o` on the next cycle.
- R9: Isolation is not cleared by the switch-over crossing, by time on backup, or by `supply_up_i` alone.
- R10: `prim_sel_o` becomes 1 on the cycle after an edge where the block is on backup and `sec_weak_i` is high. `sec_weak_i` has no effect while the supply is valid or inside the window.
- R11: Once 1, `prim_sel_o` stays 1 even after `sec_weak_i` drops. It returns to 0 on the cycle after `supply_up_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_cross_i | input | 1 | Pulse: supply fell through the failure threshold |
| swo_cross_i | input | 1 | Pulse: supply fell through the switch-over voltage |
| supply_up_i | input | 1 | Pulse: supply became valid again |
| ce_midband_i | input | 1 | Chip enable is inside the mid-supply band |
| ce_over_i | input | 1 | Chip enable is above the upper band limit |
| cell_attach_i | input | 1 | Pulse: a backup cell was just connected |
| sec_weak_i | input | 1 | Rechargeable cell is below its usable level |
| batt_isolated_o | output | 1 | 1 = cells isolated from the outputs, 0 = connected |
| prim_sel_o | output | 1 | 1 = primary cell carries the load, 0 = rechargeable |

## Verification
The bench aims at the hold boundary. A run of exactly HOLD_CYCLES edges must isolate and a run one edge shorter must not. A counter that is off by one, or that does not restart when the band drops, fails one of these two cases. The bench also raises the over-limit flag on the very edge of the switch-over crossing, which catches a design that samples spoiling only before the decision. It abandons a window with a supply return and checks that the cell does not reconnect on `supply_up_i` alone, or after an attach with no supply application, so a design that reconnects too early or leaves a stale window open gets caught. Finally it drops the weak-cell flag during backup to show that the cell choice does not fall back to the rechargeable cell.

// File: rtl/bid_pkg.sv
package bid_pkg;

    typedef enum logic [1:0] {
        PH_POWERED = 2'd0,
        PH_WINDOW  = 2'd1,
        PH_BACKUP  = 2'd2
    } bid_phase_e;

    typedef struct packed {
        logic fail_cross;
        logic swo_cross;
        logic restore;
    } supply_evt_t;

    typedef struct packed {
        logic mid;
        logic over;
    } ce_band_t;

    localparam int unsigned BID_DEF_HOLD = 70;

    function automatic logic is_removal(input bid_phase_e ph, input supply_evt_t ev);
        return (ph == PH_POWERED) && (ev.fail_cross || ev.swo_cross);
    endfunction

    function automatic bid_phase_e next_phase(input bid_phase_e ph, input supply_evt_t ev);
        bid_phase_e nx;
        nx = ph;
        unique case (ph)
            PH_POWERED: begin
                if (ev.swo_cross)       nx = PH_BACKUP;
                else if (ev.fail_cross) nx = PH_WINDOW;
            end
            PH_WINDOW: begin
                if (ev.restore)        nx = PH_POWERED;
                else if (ev.swo_cross) nx = PH_BACKUP;
            end
            PH_BACKUP: begin
                if (ev.restore) nx = PH_POWERED;
            end
            default: nx = PH_POWERED;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/bid_phase_fsm.sv
module bid_phase_fsm
    import bid_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  supply_evt_t evt,
    output bid_phase_e  phase,
    output logic        decide
);
    bid_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_POWERED;
        else     phase_q <= next_phase(phase_q, evt);
    end

    assign phase  = phase_q;
    assign decide = (phase_q == PH_WINDOW) && evt.swo_cross && !evt.restore;

    // R7: a restore inside the window always returns to the valid-supply phase
    p_restore_leaves_window_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WINDOW && evt.restore) |=> (phase_q == PH_POWERED));

endmodule

// File: rtl/bid_hold_timer.sv
module bid_hold_timer
    import bid_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = BID_DEF_HOLD
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     win_act,
    input  ce_band_t band,
    output logic     qual_ok
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_MAX  = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          met_q;
    logic          spoil_q;

    always_ff @(posedge clk) begin
        if (rst || !win_act) begin
            cnt_q   <= '0;
            met_q   <= 1'b0;
            spoil_q <= 1'b0;
        end else begin
            if (band.mid) begin
                if (cnt_q != HOLD_MAX) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == HOLD_LAST || cnt_q == HOLD_MAX) met_q <= 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (band.over) spoil_q <= 1'b1;
        end
    end

    assign qual_ok = met_q && !spoil_q && !band.over;

    // R5: once spoiled, a window stays spoiled while it lasts
    p_spoil_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (spoil_q && win_act) |=> spoil_q);

    // R4: the hold can only complete on an edge where the band flag was high
    p_met_needs_mid_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(met_q) |-> $past(band.mid));

endmodule

// File: rtl/bid_cell_select.sv
module bid_cell_select
    import bid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic on_backup,
    input  logic restore,
    input  logic sec_weak,
    output logic use_prim
);
    logic prim_q;

    always_ff @(posedge clk) begin
        if (rst || restore)            prim_q <= 1'b0;
        else if (on_backup && sec_weak) prim_q <= 1'b1;
    end

    assign use_prim = prim_q;

    // R10: primary selection only begins on backup with a weak rechargeable cell
    p_prim_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(prim_q) |-> $past(on_backup && sec_weak));

    // R11: the choice holds until the supply returns
    p_prim_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (prim_q && !restore) |=> prim_q);

endmodule

// File: rtl/batt_iso_detect.sv
module batt_iso_detect
    import bid_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = BID_DEF_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_cross_i,
    input  logic swo_cross_i,
    input  logic supply_up_i,
    input  logic ce_midband_i,
    input  logic ce_over_i,
    input  logic cell_attach_i,
    input  logic sec_weak_i,
    output logic batt_isolated_o,
    output logic prim_sel_o
);
    supply_evt_t evt;
    ce_band_t    band;
    bid_phase_e  phase;
    logic        decide;
    logic        qual_ok;
    logic        removal;
    logic        iso_q;
    logic        armed_q;

    assign evt  = '{fail_cross: fail_cross_i, swo_cross: swo_cross_i, restore: supply_up_i};
    assign band = '{mid: ce_midband_i, over: ce_over_i};

    bid_phase_fsm u_phase (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .phase  (phase),
        .decide (decide)
    );

    bid_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_act (phase == PH_WINDOW),
        .band    (band),
        .qual_ok (qual_ok)
    );

    bid_cell_select u_cell (
        .clk       (clk),
        .rst       (rst),
        .on_backup (phase == PH_BACKUP),
        .restore   (supply_up_i),
        .sec_weak  (sec_weak_i),
        .use_prim  (prim_sel_o)
    );

    assign removal = is_removal(phase, evt);

    always_ff @(posedge clk) begin
        if (rst || cell_attach_i) begin
            iso_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (decide && qual_ok) begin
            iso_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (removal && armed_q) begin
            iso_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (supply_up_i && iso_q) begin
            armed_q <= 1'b1;
        end
    end

    assign batt_isolated_o = iso_q;

    // R2: a fresh cell always starts isolated
    p_attach_isolates_r2: assert property (@(posedge clk) disable iff (rst)
        cell_attach_i |=> batt_isolated_o);

    // R3: a qualified request at the switch-over crossing isolates
    p_valid_request_r3: assert property (@(posedge clk) disable iff (rst)
        (decide && qual_ok) |=> batt_isolated_o);

    // R8: reconnection happens only at a supply removal
    p_reconnect_at_removal_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(batt_isolated_o) |-> $past(removal));

    // R9: supply return alone never reconnects
    p_restore_keeps_iso_r9: assert property (@(posedge clk) disable iff (rst)
        (batt_isolated_o && supply_up_i && !removal) |=> batt_isolated_o);

endmodule

// File: tb/batt_iso_detect_tb.sv
module batt_iso_detect_tb;
    localparam int HOLD = 70;

    typedef struct {
        logic  iso;
        logic  prim;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fail_cross = 0, swo_cross = 0, supply_up = 0;
    logic ce_mid = 0, ce_over = 0, attach = 0, sec_weak = 0;
    logic iso, prim;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    batt_iso_detect #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .fail_cross_i    (fail_cross),
        .swo_cross_i     (swo_cross),
        .supply_up_i     (supply_up),
        .ce_midband_i    (ce_mid),
        .ce_over_i       (ce_over),
        .cell_attach_i   (attach),
        .sec_weak_i      (sec_weak),
        .batt_isolated_o (iso),
        .prim_sel_o      (prim)
    );

    // monitor: pops expectations and compares against the outputs
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_total++;
            if (iso !== e.iso || prim !== e.prim) begin
                n_fail++;
                $display("FAIL %s: iso=%b prim=%b expected iso=%b prim=%b",
                         e.tag, iso, prim, e.iso, e.prim);
            end
        end
    end

    task automatic expect_out(input logic e_iso, input logic e_prim, input string tag);
        exp_t e;
        e.iso = e_iso; e.prim = e_prim; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 fail, 1 swo, 2 up, 3 attach
    task automatic pulse(input int which);
        case (which)
            0: fail_cross = 1;
            1: swo_cross  = 1;
            2: supply_up  = 1;
            default: attach = 1;
        endcase
        @(negedge clk);
        fail_cross = 0; swo_cross = 0; supply_up = 0; attach = 0;
    endtask

    task automatic mid_run(input int n);
        ce_mid = 1;
        repeat (n) @(negedge clk);
        ce_mid = 0;
    endtask

    initial begin
        tick(3);
        expect_out(1, 0, "R1 during reset");
        tick(1);
        rst = 0;
        tick(1);
        expect_out(1, 0, "R1 after reset");

        // no supply application since start: removal keeps isolation
        pulse(0);
        expect_out(1, 0, "R2 removal without supply application");
        pulse(1);
        tick(5);
        expect_out(1, 0, "R9 backup keeps isolation");
        pulse(2);
        expect_out(1, 0, "R9 supply_up alone keeps isolation");
        pulse(0);
        expect_out(0, 0, "R8 reconnect on removal after supply_up");

        // valid request
        mid_run(HOLD);
        tick(2);
        expect_out(0, 0, "R3 no isolation before switch-over");
        pulse(1);
        expect_out(1, 0, "R3 exact hold isolates");
        sec_weak = 1;
        tick(1);
        expect_out(1, 1, "R10 weak cell on backup selects primary");
        sec_weak = 0;
        tick(3);
        expect_out(1, 1, "R11 primary stays after weak flag drops");
        pulse(2);
        expect_out(1, 0, "R11 supply_up returns to rechargeable");

        // reconnect, then one edge short
        pulse(0);
        expect_out(0, 0, "R8 reconnect after isolating power-down");
        mid_run(HOLD - 1);
        pulse(1);
        expect_out(0, 0, "R4 hold one edge short");
        pulse(2);

        // over-limit inside window
        pulse(0);
        mid_run(HOLD);
        ce_over = 1; tick(1); ce_over = 0;
        tick(2);
        pulse(1);
        expect_out(0, 0, "R5 over-limit inside window");
        pulse(2);

        // over-limit on the switch-over edge
        pulse(0);
        mid_run(HOLD);
        ce_over = 1; swo_cross = 1;
        tick(1);
        ce_over = 0; swo_cross = 0;
        expect_out(0, 0, "R5 over-limit on switch-over edge");
        pulse(2);

        // broken run
        pulse(0);
        mid_run(HOLD / 2 + 5);
        tick(1);
        mid_run(HOLD / 2 + 5);
        pulse(1);
        expect_out(0, 0, "R4 broken run does not qualify");
        pulse(2);

        // band activity while supply valid is ignored
        mid_run(HOLD + 5);
        ce_over = 1; tick(2); ce_over = 0;
        sec_weak = 1;
        tick(1);
        expect_out(0, 0, "R10 weak flag ignored while supply valid");
        pulse(0);
        expect_out(0, 0, "R10 weak flag ignored inside window");
        sec_weak = 0;
        pulse(1);
        expect_out(0, 0, "R6 band before window ignored");
        mid_run(HOLD + 5);
        pulse(2);
        expect_out(0, 0, "R6 band on backup ignored");

        // abandoned window
        pulse(0);
        mid_run(HOLD);
        pulse(2);
        tick(2);
        pulse(1);
        expect_out(0, 0, "R7 abandoned window does not isolate");
        pulse(2);

        // attach while powered
        pulse(3);
        expect_out(1, 0, "R2 attach isolates");
        pulse(0);
        expect_out(1, 0, "R2 attach needs supply application");
        pulse(1);
        pulse(2);
        pulse(0);
        expect_out(0, 0, "R8 reconnect after attach and supply cycle");

        tick(3);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule